// File: doc/BRIEF.md
# Three-Leg Complementary Gate Dead-Time Inserter

The block turns one PWM command bit per inverter leg into a pair of gate drives, one for the high-side switch and one for the low-side switch of that leg. The high-side gate follows the command and the low-side gate follows its inverse. Every time the command of a leg changes, both gates of that leg are first held off for a blanking interval. The length of that interval is a runtime count of clock cycles. At a 20 MHz clock, a 2.5 us gap is a count of 50.

The blanking counter of a leg restarts whenever the command changes again before the interval has run out. A pulse shorter than the blanking interval therefore never reaches a gate. Both switches of one leg can never be driven on together. Dropping the enable, or asserting reset, turns every gate off. After enable returns, a full blanking interval passes before any gate turns on. All gate lines come straight from flops, so they carry no combinational glitches.

Top module: `gdt_top`

## Requirements
- R1: While rst_ni is low, all six gate outputs are 0.
- R2: When en_i is sampled low at a clock edge, all gate outputs are 0 after that edge.
- R3: For every leg, hi_o[l] and lo_o[l] are never both 1.
- R4: The gate that is on matches the command: for leg l, hi_o[l]=1 only if pwm_i[l] was 1 at the producing edge, and lo_o[l]=1 only if pwm_i[l] was 0 at that edge.
- R5: If pwm_i[l] differs from its value at the previous edge, the gate pair of leg l is 0 for exactly D edges (D = dead_i, 8 bits, in cycles). At the D+1-th edge the pair becomes hi=pwm, lo=!pwm, provided the command stayed unchanged.
- R6: Any further change of pwm_i[l] during the blanking interval restarts the count from zero. A command pulse shorter than D cycles therefore never turns on its gate.
- R7: With D=0, the outputs are plain complements: hi_o[l]=pwm_i[l] and lo_o[l]=!pwm_i[l], one edge later, with no gap.
- R8: After en_i rises, and after reset is released, all gates stay 0 for D edges before any gate turns on.
- R9: Legs are independent: a change on one leg's command leaves the other legs' gates unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Enable; low forces all gates off |
| pwm_i | input | 3 | PWM command, bit l for leg l |
| dead_i | input | 8 | Blanking interval in clock cycles |
| gate_hi_o | output | 3 | High-side gate drive, bit l for leg l |
| gate_lo_o | output | 3 | Low-side gate drive, bit l for leg l |

## Verification
Long, steady command pulses show the complementary pairing and the exact blanking length, including the 50-cycle interval. Pulses shorter than the blanking interval and back-to-back toggles separate a counter that restarts from one that merely delays the edge. A count of zero checks that no gap is inserted. Enable drops and single-leg toggles, mixed with random per-leg command streams and random counts, expose blanking shared across legs and a missing blank after enable.

// File: rtl/gdt_pkg.sv
package gdt_pkg;
  typedef struct packed {
    logic hi;
    logic lo;
  } gate_pair_t;

  localparam gate_pair_t GATE_OFF = '{hi: 1'b0, lo: 1'b0};

  function automatic gate_pair_t drive_pair(input logic cmd);
    gate_pair_t p;
    p.hi = cmd;
    p.lo = ~cmd;
    return p;
  endfunction
endpackage

// File: rtl/gdt_age_timer.sv
module gdt_age_timer #(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             restart_i,
  input  logic [CNT_W-1:0] dead_i,
  output logic             expired_o
);
  localparam logic [CNT_W-1:0] AGE_MAX = '1;

  logic [CNT_W-1:0] age_q, age_d;

  // age counts edges since the last command change, saturating
  always_comb begin
    if (restart_i)             age_d = '0;
    else if (age_q == AGE_MAX) age_d = age_q;
    else                       age_d = age_q + 1'b1;
  end

  assign expired_o = (age_d >= dead_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) age_q <= '0;
    else         age_q <= age_d;
  end
endmodule

// File: rtl/gdt_out_stage.sv
module gdt_out_stage (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic allow_i,
  input  logic cmd_i,
  output logic hi_o,
  output logic lo_o
);
  import gdt_pkg::*;

  gate_pair_t gate_q, gate_d;

  always_comb begin
    gate_d = GATE_OFF;
    if (en_i && allow_i) gate_d = drive_pair(cmd_i);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) gate_q <= GATE_OFF;
    else         gate_q <= gate_d;
  end

  assign hi_o = gate_q.hi;
  assign lo_o = gate_q.lo;

  p_no_shoot_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(hi_o && lo_o));

  p_dis_off_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> (!hi_o && !lo_o));

  p_on_matches_cmd_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i |=> ((!hi_o || $past(cmd_i)) && (!lo_o || !$past(cmd_i))));
endmodule

// File: rtl/gdt_leg.sv
module gdt_leg #(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             blank_i,
  input  logic             pwm_i,
  input  logic [CNT_W-1:0] dead_i,
  output logic             hi_o,
  output logic             lo_o
);
  logic cmd_q;
  logic changed;
  logic expired;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cmd_q <= 1'b0;
    else         cmd_q <= pwm_i;
  end

  // blank_i forces a fresh interval after disable or reset
  assign changed = blank_i | (pwm_i ^ cmd_q);

  gdt_age_timer #(.CNT_W(CNT_W)) u_timer (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .restart_i (changed),
    .dead_i    (dead_i),
    .expired_o (expired)
  );

  gdt_out_stage u_out (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .en_i    (en_i),
    .allow_i (expired),
    .cmd_i   (pwm_i),
    .hi_o    (hi_o),
    .lo_o    (lo_o)
  );

  p_chg_blank_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && (pwm_i != cmd_q) && (dead_i != '0)) |=> (!hi_o && !lo_o));

  p_short_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!hi_o && !lo_o && (pwm_i != cmd_q)) |=> (!hi_o && !lo_o) || (dead_i == '0));
endmodule

// File: rtl/gdt_top.sv
module gdt_top #(
  parameter int unsigned NUM_LEGS = 3,
  parameter int unsigned CNT_W    = 8
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                en_i,
  input  logic [NUM_LEGS-1:0] pwm_i,
  input  logic [CNT_W-1:0]    dead_i,
  output logic [NUM_LEGS-1:0] gate_hi_o,
  output logic [NUM_LEGS-1:0] gate_lo_o
);
  logic blank_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) blank_q <= 1'b1;
    else         blank_q <= ~en_i;
  end

  for (genvar l = 0; l < NUM_LEGS; l++) begin : g_leg
    gdt_leg #(.CNT_W(CNT_W)) u_leg (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .en_i    (en_i),
      .blank_i (blank_q),
      .pwm_i   (pwm_i[l]),
      .dead_i  (dead_i),
      .hi_o    (gate_hi_o[l]),
      .lo_o    (gate_lo_o[l])
    );
  end

  p_en_blank_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(en_i) && (dead_i != '0)) |=> (gate_hi_o == '0 && gate_lo_o == '0));

  p_on_count_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(gate_hi_o & gate_lo_o) == 0);
endmodule

// File: tb/gdt_top_test.sv
`timescale 1ns/1ps
module gdt_top_test;
  localparam int NL = 3;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          en = 1'b0;
  logic [NL-1:0] pwm = '0;
  logic [7:0]    dead = 8'd5;
  logic [NL-1:0] hi, lo;

  int checks = 0;
  int errors = 0;
  logic mon_on = 1'b0;
  string tag = "R4";
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  gdt_top uut (
    .clk_i(clk), .rst_ni(rst_n), .en_i(en), .pwm_i(pwm), .dead_i(dead),
    .gate_hi_o(hi), .gate_lo_o(lo)
  );

  // expected behaviour per leg from the requirements
  logic [NL-1:0] m_cmd, m_hi, m_lo;
  logic [7:0]    m_age [NL];
  logic          m_blank;

  function automatic logic [7:0] next_age(input logic chg, input logic [7:0] a);
    if (chg) return 8'd0;
    return (a == 8'hFF) ? a : a + 8'd1;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cmd <= '0; m_hi <= '0; m_lo <= '0; m_blank <= 1'b1;
      for (int l = 0; l < NL; l++) m_age[l] <= 8'd0;
    end else begin
      m_blank <= ~en;
      m_cmd   <= pwm;
      for (int l = 0; l < NL; l++) begin
        logic [7:0] a;
        a = next_age(m_blank | (pwm[l] != m_cmd[l]), m_age[l]);
        m_age[l] <= a;
        m_hi[l]  <= en && (a >= dead) && pwm[l];
        m_lo[l]  <= en && (a >= dead) && !pwm[l];
      end
    end
  end

  task automatic chk(input string t, input logic [7:0] got, input logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %h expected %h at %0t", t, got, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (mon_on && rst_n) begin
      chk(tag, {2'b0, hi, lo}, {2'b0, m_hi, m_lo});
      chk("R3", {5'b0, hi & lo}, 8'd0);
    end
  end

  task automatic step(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 5);
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    int off_cnt;
    bit seen;
    void'($urandom(32'd1234));
    // R1: gates off while reset is low, even with enable and commands set
    en = 1'b1; pwm = 3'b101;
    step(3);
    chk("R1", {2'b0, hi, lo}, 8'd0);
    pwm = 3'b000; dead = 8'd5;
    rst_n = 1'b1;
    mon_on = 1'b1;
    // R8: blank after reset release, low gates on after 5 edges
    tag = "R8";
    step(5);
    chk("R8", {5'b0, lo}, 8'd0);
    step(1);
    chk("R8", {2'b0, hi, lo}, {5'b0, 3'b111});
    // R5: long pulse on leg 0 with D=5
    tag = "R5";
    pwm[0] = 1'b1;
    off_cnt = 0;
    for (int i = 0; i < 12; i++) begin
      step(1);
      if (!hi[0] && !lo[0]) off_cnt++;
    end
    chk("R5", off_cnt[7:0], 8'd5);
    chk("R4", {6'b0, hi[0], lo[0]}, 8'b10);
    // R9: legs 1 and 2 unaffected
    chk("R9", {4'b0, hi[2:1], lo[2:1]}, 8'b0011);
    // R6: pulse of 3 cycles on leg 1 never turns hi on
    tag = "R6";
    seen = 1'b0;
    pwm[1] = 1'b1; step(3); pwm[1] = 1'b0;
    for (int i = 0; i < 12; i++) begin
      if (hi[1]) seen = 1'b1;
      step(1);
    end
    chk("R6", {7'b0, seen}, 8'd0);
    chk("R6", {7'b0, lo[1]}, 8'd1);
    // R5: 50-cycle blanking
    tag = "R5";
    dead = 8'd50; step(2);
    pwm[2] = 1'b1;
    off_cnt = 0;
    for (int i = 0; i < 60; i++) begin
      step(1);
      if (!hi[2] && !lo[2]) off_cnt++;
    end
    chk("R5", off_cnt[7:0], 8'd50);
    // R7: zero count gives immediate complement
    tag = "R7";
    dead = 8'd0; step(2);
    pwm = 3'b010; step(1);
    chk("R7", {2'b0, hi, lo}, {2'b0, 3'b010, 3'b101});
    pwm = 3'b101; step(1);
    chk("R7", {2'b0, hi, lo}, {2'b0, 3'b101, 3'b010});
    // R2: disable turns everything off after one edge
    tag = "R2";
    en = 1'b0; step(1);
    chk("R2", {2'b0, hi, lo}, 8'd0);
    step(3);
    // R8: re-enable with D=4
    tag = "R8";
    dead = 8'd4; en = 1'b1;
    step(4);
    chk("R8", {2'b0, hi, lo}, 8'd0);
    step(1);
    chk("R8", {2'b0, hi, lo}, {2'b0, 3'b101, 3'b010});
    // random streams, random counts, occasional disable
    tag = "R9";
    for (int i = 0; i < 6000; i++) begin
      if (i % 400 == 0) dead = 8'($urandom_range(0, 12));
      for (int l = 0; l < NL; l++)
        if ($urandom_range(0, 7) == 0) pwm[l] = ~pwm[l];
      if ($urandom_range(0, 199) == 0) en = 1'b0;
      else if (!en && $urandom_range(0, 3) == 0) en = 1'b1;
      step(1);
    end
    step(2);
    finish_run();
  end
endmodule